// File: doc/BRIEF.md
# Convolutional Byte De-interleaver

This block reverses a byte-wise convolutional interleave. Bytes arrive from the frame aligner one per valid cycle. A commutator deals them in turn to twelve branches. Each branch is a FIFO, and the delay of a branch falls as its index rises: branch 0 is the deepest and branch 11 is a straight wire. All delay lines live in one shared RAM. The RAM is carved into twelve circular regions, and each region has its own wrapping pointer. Because each branch reads its oldest byte from a slot and writes the new byte into that same slot in the same cycle, one RAM port is enough.

The commutator re-aligns on every block-start marker, so the sync byte of a block always enters branch 0. With a unit delay of 17 bytes, a 204-byte block is rebuilt into its original order 2244 valid bytes after it entered. The output stays flagged invalid until the deepest branch has been filled once. After that, every valid input byte yields exactly one valid output byte in the following clock. A block-start flag marks the first byte of each rebuilt block.

Top module: `deint_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, out_valid_o and out_sop_o are low.
- R2: out_valid_o is high only in the cycle that directly follows a cycle with in_valid_i high; a cycle with in_valid_i low is followed by out_valid_o low.
- R3: After reset, consecutive valid bytes that carry no block-start marker go to branches 0, 1, …, 11, then back to 0.
- R4: A valid byte with in_sop_i high goes to branch 0 whatever the commutator position, and the next valid byte goes to branch 1.
- R5: A byte written to branch j comes out on the (11−j)×17-th later visit to that branch. Branch 11 has no delay, so its byte appears on out_data_o in the next cycle.
- R6: out_valid_o stays low for the first 2244 valid input bytes after reset. From then on, out_valid_o is high in the cycle after each valid input byte.
- R7: When a correctly interleaved stream is fed in from reset, with a sync byte every 204 bytes starting at byte 0, the output byte produced for input byte n equals original stream byte n−2244.
- R8: out_sop_o is high together with out_valid_o exactly when the input byte that produced the output sat at block position 0. The position is reset to 0 by in_sop_i, advances by one per valid byte, and wraps after 204.
- R9: Cycles with in_valid_i low move neither the commutator nor any branch pointer, so idle gaps do not change the output byte sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_sop_i | input | 1 | Input byte is the block sync byte |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Output byte valid |
| out_sop_o | output | 1 | Output byte starts a rebuilt block |
| out_data_o | output | 8 | De-interleaved output byte |

## Verification
The assertions assume that in_sop_i is only meaningful together with in_valid_i, and that the stream is frame-aligned, so a marker arrives every 204 valid bytes once lock is reached. The stimulus holds to these assumptions in every scenario, including those that start with stray bytes. In those scenarios the marker arrives with the commutator off branch 0 and forces the realignment. Idle gaps of one or two cycles are mixed into the stream to show that stalls leave the pointers untouched.

// File: rtl/deint_pkg.sv
package deint_pkg;

  // Depth of branch j in unit steps times unit.
  function automatic int unsigned br_len(input int unsigned nbr, input int unsigned unit,
                                         input int unsigned j);
    return (nbr - 1 - j) * unit;
  endfunction

  // First RAM word of branch j: sum of lengths of the lower branches.
  function automatic int unsigned br_base(input int unsigned nbr, input int unsigned unit,
                                          input int unsigned j);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < j; i++) acc += (nbr - 1 - i) * unit;
    return acc;
  endfunction

  function automatic int unsigned ram_words(input int unsigned nbr, input int unsigned unit);
    return unit * nbr * (nbr - 1) / 2;
  endfunction

  typedef struct packed {
    logic vld;
    logic sop;
    logic byp;
  } stage_t;

endpackage

// File: rtl/deint_commutator.sv
module deint_commutator #(
  parameter int unsigned NUM_BR = 12,
  parameter int unsigned BLK    = 204,
  localparam int unsigned BW    = $clog2(NUM_BR),
  localparam int unsigned PSW   = $clog2(BLK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sop_i,
  output logic [BW-1:0] sel_o,
  output logic          head_o
);

  logic [BW-1:0]  idx_q;
  logic [PSW-1:0] pos_q;
  logic [PSW-1:0] pos_cur;

  // Marker realigns both the branch index and the block position.
  assign sel_o   = sop_i ? '0 : idx_q;
  assign pos_cur = sop_i ? '0 : pos_q;
  assign head_o  = (pos_cur == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      pos_q <= '0;
    end else if (valid_i) begin
      idx_q <= (sel_o == BW'(NUM_BR - 1)) ? '0 : sel_o + 1'b1;
      pos_q <= (pos_cur == PSW'(BLK - 1)) ? '0 : pos_cur + 1'b1;
    end
  end

endmodule

// File: rtl/deint_ptr_bank.sv
module deint_ptr_bank #(
  parameter int unsigned NUM_BR = 12,
  parameter int unsigned UNIT   = 17,
  localparam int unsigned BW    = $clog2(NUM_BR),
  localparam int unsigned DEPTH = deint_pkg::ram_words(NUM_BR, UNIT),
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = $clog2((NUM_BR - 1) * UNIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [BW-1:0] sel_i,
  output logic [AW-1:0] addr_o,
  output logic          bypass_o
);

  logic [AW-1:0]     base_w [NUM_BR];
  logic [PW-1:0]     ptr_w  [NUM_BR];
  logic [NUM_BR-1:0] zero_w;

  for (genvar j = 0; j < NUM_BR; j++) begin : g_br
    localparam int unsigned LEN  = deint_pkg::br_len(NUM_BR, UNIT, j);
    localparam int unsigned BASE = deint_pkg::br_base(NUM_BR, UNIT, j);
    assign base_w[j] = AW'(BASE);
    if (LEN == 0) begin : g_wire
      assign ptr_w[j]  = '0;
      assign zero_w[j] = 1'b1;
    end else begin : g_ring
      logic [PW-1:0] ptr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ptr_q <= '0;
        else if (valid_i && sel_i == BW'(j))
          ptr_q <= (ptr_q == PW'(LEN - 1)) ? '0 : ptr_q + 1'b1;
      end
      assign ptr_w[j]  = ptr_q;
      assign zero_w[j] = 1'b0;
    end
  end

  always_comb begin
    addr_o   = '0;
    bypass_o = 1'b0;
    for (int unsigned j = 0; j < NUM_BR; j++) begin
      if (sel_i == BW'(j)) begin
        addr_o   = base_w[j] + AW'(ptr_w[j]);
        bypass_o = zero_w[j];
      end
    end
  end

endmodule

// File: rtl/deint_ram.sv
module deint_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 1122,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  // Read-first: the oldest byte leaves as the newest takes its slot.
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      rdata_o        <= mem_q[addr_i];
      mem_q[addr_i]  <= wdata_i;
    end
  end

endmodule

// File: rtl/deint_prime.sv
module deint_prime #(
  parameter int unsigned LIMIT = 2244,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic primed_o
);

  logic [CW-1:0] cnt_q;

  assign primed_o = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid_i && !primed_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/deint_top.sv
module deint_top #(
  parameter int unsigned NUM_BR = 12,
  parameter int unsigned UNIT   = 17,
  parameter int unsigned DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_sop_i,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic          out_sop_o,
  output logic [DW-1:0] out_data_o
);

  localparam int unsigned BW    = $clog2(NUM_BR);
  localparam int unsigned BLK   = NUM_BR * UNIT;
  localparam int unsigned DEPTH = deint_pkg::ram_words(NUM_BR, UNIT);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned PRIME = (NUM_BR - 1) * UNIT * NUM_BR;

  logic [BW-1:0] br_sel;
  logic          blk_head;
  logic [AW-1:0] ram_addr;
  logic          bypass;
  logic          primed;
  logic [DW-1:0] ram_rdata;

  deint_pkg::stage_t st_q;
  logic [DW-1:0]     byp_data_q;

  deint_commutator #(.NUM_BR(NUM_BR), .BLK(BLK)) u_comm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .sop_i  (in_sop_i),
    .sel_o  (br_sel),
    .head_o (blk_head)
  );

  deint_ptr_bank #(.NUM_BR(NUM_BR), .UNIT(UNIT)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .sel_i   (br_sel),
    .addr_o  (ram_addr),
    .bypass_o(bypass)
  );

  deint_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk_i  (clk_i),
    .en_i   (in_valid_i && !bypass),
    .addr_i (ram_addr),
    .wdata_i(in_data_i),
    .rdata_o(ram_rdata)
  );

  deint_prime #(.LIMIT(PRIME)) u_prime (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .primed_o(primed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= '0;
      byp_data_q <= '0;
    end else begin
      st_q.vld <= in_valid_i && primed;
      st_q.sop <= in_valid_i && primed && blk_head;
      if (in_valid_i) begin
        st_q.byp   <= bypass;
        byp_data_q <= in_data_i;
      end
    end
  end

  assign out_valid_o = st_q.vld;
  assign out_sop_o   = st_q.sop;
  assign out_data_o  = st_q.byp ? byp_data_q : ram_rdata;

endmodule

// File: rtl/deint_top_chk.sv
module deint_top_chk #(
  parameter int unsigned NUM_BR = 12,
  parameter int unsigned UNIT   = 17,
  parameter int unsigned DW     = 8,
  localparam int unsigned BW    = $clog2(NUM_BR),
  localparam int unsigned PRIME = (NUM_BR - 1) * UNIT * NUM_BR,
  localparam int unsigned CW    = $clog2(PRIME + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_sop_i,
  input logic [DW-1:0] in_data_i,
  input logic          out_valid_o,
  input logic          out_sop_o,
  input logic [DW-1:0] out_data_o,
  input logic [BW-1:0] sel_i
);

  logic [CW-1:0] seen_q;
  logic [BW-1:0] exp_sel_q;
  logic          full;

  assign full = (seen_q >= CW'(PRIME));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q    <= '0;
      exp_sel_q <= '0;
    end else if (in_valid_i) begin
      if (!full) seen_q <= seen_q + 1'b1;
      exp_sel_q <= (sel_i == BW'(NUM_BR - 1)) ? '0 : sel_i + 1'b1;
    end
  end

  AST_OUT_AFTER_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i)); // R2
  AST_IDLE_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R2
  AST_SOP_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> out_valid_o); // R8
  AST_PRIME_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !full) |=> !out_valid_o); // R6
  AST_PRIMED_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && full) |=> out_valid_o); // R6
  AST_SYNC_BRANCH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sop_i) |-> sel_i == '0); // R4
  AST_BRANCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_sop_i) |-> sel_i == exp_sel_q); // R3
  AST_ZERO_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && full && sel_i == BW'(NUM_BR - 1)) |=> out_data_o == $past(in_data_i)); // R5

endmodule

bind deint_top deint_top_chk #(.NUM_BR(NUM_BR), .UNIT(UNIT), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_sop_i   (in_sop_i),
  .in_data_i  (in_data_i),
  .out_valid_o(out_valid_o),
  .out_sop_o  (out_sop_o),
  .out_data_o (out_data_o),
  .sel_i      (br_sel)
);

// File: tb/deint_top_test.sv
module deint_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_BR     = 12;
  localparam int UNIT       = 17;
  localparam int BLK        = NUM_BR * UNIT;
  localparam int PRIME      = (NUM_BR - 1) * UNIT * NUM_BR;
  localparam int WATCHDOG   = 150000;

  // lead stray bytes, stream bytes, gap mode, data mode (0 interleaved, 1 arbitrary)
  localparam int SCN [4][4] = '{
    '{0, 3264, 0, 0},
    '{0, 2856, 1, 0},
    '{5, 2856, 1, 1},
    '{7, 2856, 2, 1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sop = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, out_sop;
  logic [7:0] out_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // reference model state
  logic [7:0] mq [NUM_BR][$];
  int m_idx, m_pos, m_cnt;
  bit closed_form;
  string data_tag;

  always #(CLK_PERIOD / 2) clk = ~clk;

  deint_top uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_sop_i   (in_sop),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_sop_o  (out_sop),
    .out_data_o (out_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] orig(input int k);
    return (k % BLK == 0) ? 8'h47 : 8'((k * 7 + 3) ^ (k >> 5));
  endfunction

  function automatic logic [7:0] ilv(input int n);
    int k;
    k = n - BLK * (n % NUM_BR);
    return (k >= 0) ? orig(k) : 8'h00;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sop = 1'b0;
    in_data = '0;
    for (int b = 0; b < NUM_BR; b++) mq[b].delete();
    m_idx = 0;
    m_pos = 0;
    m_cnt = 0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_sop, "R1 reset outputs", {out_valid, out_sop}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_sop, "R1 after release", {out_valid, out_sop}, 0);
  endtask

  task automatic step(input bit v, input bit s, input logic [7:0] d, input int n);
    int j, pos, len;
    bit ev, es, have;
    logic [7:0] ed;
    in_valid = v;
    in_sop = s;
    in_data = d;
    ev = 0; es = 0; have = 0; ed = '0;
    if (v) begin
      j   = s ? 0 : m_idx;
      pos = s ? 0 : m_pos;
      ev  = (m_cnt >= PRIME);
      es  = ev && (pos == 0);
      len = (NUM_BR - 1 - j) * UNIT;
      if (len == 0) begin
        have = 1; ed = d;
      end else begin
        mq[j].push_back(d);
        if (mq[j].size() > len) begin
          ed = mq[j].pop_front();
          have = 1;
        end
      end
      m_idx = (j == NUM_BR - 1) ? 0 : j + 1;
      m_pos = (pos == BLK - 1) ? 0 : pos + 1;
      if (m_cnt < PRIME) m_cnt++;
    end
    @(negedge clk);
    if (v) begin
      check(out_valid == ev, "R6 valid after priming count", out_valid, ev);
      if (ev) begin
        check(out_sop == es, "R8 block start flag", out_sop, es);
        // wrong branch order (R3) also shows as a data mismatch here
        if (have) check(out_data == ed, data_tag, out_data, ed);
        if (closed_form && n >= PRIME)
          check(out_data == orig(n - PRIME), "R7 original order", out_data, orig(n - PRIME));
      end
    end else begin
      check(!out_valid, "R2 no output after idle", out_valid, 0);
    end
  endtask

  initial begin
    for (int sc = 0; sc < 4; sc++) begin
      do_reset();
      closed_form = (SCN[sc][3] == 0) && (SCN[sc][0] == 0);
      data_tag = (SCN[sc][0] > 0) ? "R4 data after resync" :
                 (SCN[sc][2] > 0) ? "R9 data with gaps" : "R5 branch delay data";
      for (int k = 0; k < SCN[sc][0]; k++) step(1'b1, 1'b0, 8'(8'hA0 + k), -1);
      for (int i = 0; i < SCN[sc][1]; i++) begin
        logic [7:0] d;
        d = (SCN[sc][3] == 0) ? ilv(i) : 8'((i * 37 + sc * 11) ^ (i >> 3));
        step(1'b1, (i % BLK) == 0, d, i);
        if (SCN[sc][2] == 1 && (i % 3) == 2) step(1'b0, 1'b0, 8'hEE, -1);
        if (SCN[sc][2] == 2 && (i % 5) == 4) begin
          step(1'b0, 1'b1, 8'hEE, -1);
          step(1'b0, 1'b0, 8'hEE, -1);
        end
      end
      for (int k = 0; k < 8; k++) step(1'b0, 1'b0, 8'h00, -1);
    end

    // directed: priming boundary at exactly PRIME bytes
    do_reset();
    closed_form = 1'b0;
    data_tag = "R5 branch delay data";
    for (int i = 0; i < PRIME - 1; i++) step(1'b1, (i % BLK) == 0, 8'(i), i);
    in_valid = 1'b1; in_sop = 1'b0; in_data = 8'h11;
    @(negedge clk);
    m_cnt++;
    check(!out_valid, "R6 last unprimed byte", out_valid, 0);
    // byte PRIME lands on branch 0 as a sync (PRIME is a block multiple)
    in_valid = 1'b1; in_sop = 1'b1; in_data = 8'h22;
    @(negedge clk);
    check(out_valid && out_sop, "R6 R8 first primed byte", {out_valid, out_sop}, 3);
    check(out_data == 8'h00, "R5 branch 0 oldest byte", out_data, 0);
    in_valid = 1'b0; in_sop = 1'b0;
    @(negedge clk);
    check(!out_valid, "R2 idle after stream", out_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule